// File: doc/BRIEF.md
# USB Endpoint Status Register

This block is the status byte a CPU reads for the currently selected USB device endpoint. It decides whether the requested endpoint size and bank count fit in the FIFO space. That decision is made only when software asks for an allocation. The block also latches isochronous overflow and underflow errors until software acknowledges them, and it raises an endpoint error interrupt request while an error is pending and the interrupt is enabled.

The low half of the byte passes through live state from the endpoint engine: the data-toggle PID and the number of busy banks. The toggle reported depends on the transfer direction. An OUT endpoint shows the toggle last received on the current bank. An IN endpoint shows the toggle that the next transmitted packet will carry.

The read value is combinational from the flags and inputs. Flag updates take effect on the clock edge at which the cause is sampled.

Top module: `ep_status_reg`

## Requirements
- R1: After reset, `reg_rdata` bits 7:5 are 0 and `ep_irq` is 0.
- R2: On a clock edge with `alloc_req` high, bit 7 (configuration OK) becomes 1 if (8 << `cfg_size_code`) × (2 if `cfg_two_banks` else 1) ≤ `FIFO_BYTES` (default 176), and becomes 0 otherwise.
- R3: Without `alloc_req`, bit 7 holds its value even when `cfg_size_code` or `cfg_two_banks` change.
- R4: With `cfg_iso` high, an `ovf_evt` pulse sets bit 6 and an `unf_evt` pulse sets bit 5. The same pulses are ignored when `cfg_iso` is low.
- R5: A write (`reg_wr`) with a data bit of 0 clears flag bit 6 or 5. A data bit of 1 leaves that flag unchanged. Written bits 7, 4, 3:2 and 1:0 have no effect.
- R6: When an error event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R7: `ep_enable` low, or a `cfg_reset` pulse, clears both error flags on that edge, and this takes priority over a simultaneous event.
- R8: `ep_irq` is high exactly when `flow_err_ie` is 1 and bit 6 or bit 5 is set.
- R9: Bit 4 always reads 0. Bits 1:0 show `busy_banks`. Bits 3:2 show the toggle code (00 = DATA0, 01 = DATA1, 10/11 reserved): `tx_toggle` when `cfg_dir_in` is 1 (IN), and `rx_toggle` when it is 0 (OUT).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | CPU write strobe for the status byte |
| reg_wdata | input | 8 | CPU write data |
| reg_rdata | output | 8 | Status byte read value |
| cfg_size_code | input | 3 | Endpoint size code, size = 8 << code bytes |
| cfg_two_banks | input | 1 | 1 = two banks, 0 = one bank |
| cfg_iso | input | 1 | Endpoint is isochronous |
| cfg_dir_in | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| alloc_req | input | 1 | Allocation request, triggers the capacity check |
| ep_enable | input | 1 | Endpoint enabled; low clears the error flags |
| cfg_reset | input | 1 | Configuration reset pulse; clears the error flags |
| ovf_evt | input | 1 | Overflow error event pulse |
| unf_evt | input | 1 | Underflow error event pulse |
| flow_err_ie | input | 1 | Flow-error interrupt enable |
| rx_toggle | input | 2 | Last toggle received on the current bank |
| tx_toggle | input | 2 | Toggle for the next packet to send |
| busy_banks | input | 2 | Busy-bank count from the endpoint engine |
| ep_irq | output | 1 | Endpoint error interrupt request |

## Verification
Two pairs of functions can act in the same cycle. The first pair is an error event and the CPU's write-zero acknowledge of the same flag. The second pair is an error event and a flush, caused by the endpoint being disabled or its configuration being reset. The bench drives both causes of each pair in one clock. It then judges the outcome from the byte read afterwards: the event wins over the write, and the flush wins over the event. A write of ones after a set, and a clear of one flag while the other stays pending, show that acknowledges touch only the bit they target.

// File: rtl/ep_status_pkg.sv
package ep_status_pkg;

  localparam int SIZE_CODE_W = 3;
  localparam int BYTES_W     = 8 + (1 << SIZE_CODE_W) - 1 + 1 + 1;

  // Bit positions of the status byte (software decodes these)
  localparam int BIT_CFG_OK = 7;
  localparam int BIT_OVF    = 6;
  localparam int BIT_UNF    = 5;
  localparam int BIT_RSVD   = 4;

  typedef enum logic [1:0] {
    TOG_DATA0 = 2'b00,
    TOG_DATA1 = 2'b01,
    TOG_RSV2  = 2'b10,
    TOG_RSV3  = 2'b11
  } toggle_e;

  // Bytes for one bank of the given size code
  function automatic logic [BYTES_W-1:0] bank_bytes(input logic [SIZE_CODE_W-1:0] code);
    logic [BYTES_W-1:0] one;
    one = BYTES_W'(8);
    return one << code;
  endfunction

  // Total bytes requested across all banks
  function automatic logic [BYTES_W-1:0] total_bytes(input logic [SIZE_CODE_W-1:0] code,
                                                     input logic two_banks);
    logic [BYTES_W-1:0] b;
    b = bank_bytes(code);
    return two_banks ? (b << 1) : b;
  endfunction

  function automatic logic fits_fifo(input logic [SIZE_CODE_W-1:0] code,
                                     input logic two_banks,
                                     input int   capacity);
    return int'(total_bytes(code, two_banks)) <= capacity;
  endfunction

endpackage

// File: rtl/ep_cfg_checker.sv
module ep_cfg_checker
  import ep_status_pkg::*;
#(
  parameter int FIFO_BYTES = 176
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc_req,
  input  logic [SIZE_CODE_W-1:0] size_code,
  input  logic                   two_banks,
  output logic                   cfg_ok,
  output logic                   fit_now
);

  assign fit_now = fits_fifo(size_code, two_banks, FIFO_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cfg_ok <= 1'b0;
    else if (alloc_req) cfg_ok <= fit_now;
  end

endmodule

// File: rtl/ep_err_flag.sv
module ep_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic hit,
  input  logic ack_clr,
  output logic flag
);

  // Priority: flush, then event, then software acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (flush)   flag <= 1'b0;
    else if (hit)     flag <= 1'b1;
    else if (ack_clr) flag <= 1'b0;
  end

endmodule

// File: rtl/ep_toggle_view.sv
module ep_toggle_view
  import ep_status_pkg::*;
(
  input  logic       dir_in,
  input  logic [1:0] rx_toggle,
  input  logic [1:0] tx_toggle,
  output toggle_e    shown
);

  always_comb begin
    if (dir_in) shown = toggle_e'(tx_toggle);
    else        shown = toggle_e'(rx_toggle);
  end

endmodule

// File: rtl/ep_status_reg.sv
module ep_status_reg
  import ep_status_pkg::*;
#(
  parameter int FIFO_BYTES = 176
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [2:0] cfg_size_code,
  input  logic       cfg_two_banks,
  input  logic       cfg_iso,
  input  logic       cfg_dir_in,
  input  logic       alloc_req,
  input  logic       ep_enable,
  input  logic       cfg_reset,
  input  logic       ovf_evt,
  input  logic       unf_evt,
  input  logic       flow_err_ie,
  input  logic [1:0] rx_toggle,
  input  logic [1:0] tx_toggle,
  input  logic [1:0] busy_banks,
  output logic       ep_irq
);

  localparam int N_ERR = 2;   // index 1 = overflow, 0 = underflow

  // Named internal events (observed by the checker)
  logic             flush;
  logic             ovf_hit;
  logic             unf_hit;
  logic             cfg_ok;
  logic             fit_now;
  logic [N_ERR-1:0] err_hit;
  logic [N_ERR-1:0] err_ack;
  logic [N_ERR-1:0] err_flag;
  toggle_e          tog_shown;

  assign flush   = !ep_enable || cfg_reset;
  assign ovf_hit = ovf_evt && cfg_iso;
  assign unf_hit = unf_evt && cfg_iso;
  assign err_hit = {ovf_hit, unf_hit};
  assign err_ack = {reg_wr && !reg_wdata[BIT_OVF], reg_wr && !reg_wdata[BIT_UNF]};

  ep_cfg_checker #(.FIFO_BYTES(FIFO_BYTES)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_req (alloc_req),
    .size_code (cfg_size_code),
    .two_banks (cfg_two_banks),
    .cfg_ok    (cfg_ok),
    .fit_now   (fit_now)
  );

  for (genvar i = 0; i < N_ERR; i++) begin : g_err
    ep_err_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .hit     (err_hit[i]),
      .ack_clr (err_ack[i]),
      .flag    (err_flag[i])
    );
  end

  ep_toggle_view u_tog (
    .dir_in    (cfg_dir_in),
    .rx_toggle (rx_toggle),
    .tx_toggle (tx_toggle),
    .shown     (tog_shown)
  );

  always_comb begin
    reg_rdata             = '0;
    reg_rdata[BIT_CFG_OK] = cfg_ok;
    reg_rdata[BIT_OVF]    = err_flag[1];
    reg_rdata[BIT_UNF]    = err_flag[0];
    reg_rdata[BIT_RSVD]   = 1'b0;
    reg_rdata[3:2]        = tog_shown;
    reg_rdata[1:0]        = busy_banks;
  end

  assign ep_irq = flow_err_ie && (|err_flag);

endmodule

// File: rtl/ep_status_chk.sv
module ep_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       alloc_req,
  input logic       cfg_iso,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic       flow_err_ie,
  input logic [7:0] reg_rdata,
  input logic       ep_irq,
  input logic       flush,
  input logic       ovf_hit,
  input logic       unf_hit
);

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_req |=> $stable(reg_rdata[7])); // R3
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_hit && !flush) |=> reg_rdata[6]); // R4
  AST_UNF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_hit && !flush) |=> reg_rdata[5]); // R4
  AST_NONISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_iso && !reg_rdata[6]) |=> !reg_rdata[6]); // R4
  AST_WR0_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_wdata[6] && !ovf_hit) |=> !reg_rdata[6]); // R5
  AST_EVENT_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_wdata[5] && unf_hit && !flush) |=> reg_rdata[5]); // R6
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (reg_rdata[6:5] == 2'b00)); // R7
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ep_irq == (flow_err_ie && (reg_rdata[6] || reg_rdata[5]))); // R8

endmodule

bind ep_status_reg ep_status_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .alloc_req   (alloc_req),
  .cfg_iso     (cfg_iso),
  .reg_wr      (reg_wr),
  .reg_wdata   (reg_wdata),
  .flow_err_ie (flow_err_ie),
  .reg_rdata   (reg_rdata),
  .ep_irq      (ep_irq),
  .flush       (flush),
  .ovf_hit     (ovf_hit),
  .unf_hit     (unf_hit)
);

// File: tb/tb_ep_status_reg.sv
module tb_ep_status_reg;

  localparam int CAP = 176;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [2:0] cfg_size_code = 3'd0;
  logic       cfg_two_banks = 1'b0;
  logic       cfg_iso = 1'b1;
  logic       cfg_dir_in = 1'b0;
  logic       alloc_req = 1'b0;
  logic       ep_enable = 1'b1;
  logic       cfg_reset = 1'b0;
  logic       ovf_evt = 1'b0;
  logic       unf_evt = 1'b0;
  logic       flow_err_ie = 1'b0;
  logic [1:0] rx_toggle = 2'b00;
  logic [1:0] tx_toggle = 2'b00;
  logic [1:0] busy_banks = 2'b00;
  logic       ep_irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  ep_status_reg #(.FIFO_BYTES(CAP)) dut (.*);

  typedef struct {
    logic [7:0] rdata;
    logic       irq;
    string      req;
  } sb_item_t;

  sb_item_t sb_q[$];

  // Bench model of the flags
  logic m_cfg = 1'b0, m_ovf = 1'b0, m_unf = 1'b0;

  function automatic logic model_fit(input logic [2:0] code, input logic two);
    int bytes;
    bytes = 8;
    for (int k = 0; k < int'(code); k++) bytes = bytes * 2;
    if (two) bytes = bytes + bytes;
    return bytes <= CAP;
  endfunction

  function automatic logic next_flag(input logic cur, input logic evt, input logic wbit);
    if (!ep_enable || cfg_reset) return 1'b0;
    if (evt && cfg_iso)          return 1'b1;
    if (reg_wr && !wbit)         return 1'b0;
    return cur;
  endfunction

  // Advance one clock with current inputs, then queue the expected result
  task automatic step(input string req);
    logic n_cfg, n_ovf, n_unf;
    sb_item_t it;
    n_cfg = alloc_req ? model_fit(cfg_size_code, cfg_two_banks) : m_cfg;
    n_ovf = next_flag(m_ovf, ovf_evt, reg_wdata[6]);
    n_unf = next_flag(m_unf, unf_evt, reg_wdata[5]);
    @(posedge clk);
    m_cfg = n_cfg; m_ovf = n_ovf; m_unf = n_unf;
    #2;
    it.rdata = {m_cfg, m_ovf, m_unf, 1'b0, (cfg_dir_in ? tx_toggle : rx_toggle), busy_banks};
    it.irq   = flow_err_ie && (m_ovf || m_unf);
    it.req   = req;
    sb_q.push_back(it);
    @(negedge clk);
    reg_wr = 1'b0; alloc_req = 1'b0; cfg_reset = 1'b0;
    ovf_evt = 1'b0; unf_evt = 1'b0;
  endtask

  // Monitor: pops expected items and compares with the design
  initial begin
    forever begin
      sb_item_t it;
      wait (sb_q.size() != 0);
      it = sb_q.pop_front();
      checks++;
      if (reg_rdata !== it.rdata || ep_irq !== it.irq) begin
        errors++;
        $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                 it.req, reg_rdata, ep_irq, it.rdata, it.irq);
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !done) begin
        errors++;
        $display("FAIL watchdog: cycles=%0d expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (reg_rdata[7:4] !== 4'h0 || ep_irq !== 1'b0) begin
      errors++;
      $display("FAIL R1: rdata=%h irq=%b expected rdata[7:4]=0 irq=0", reg_rdata, ep_irq);
    end
    rst_n = 1'b1;
    step("R1");

    // R2 allocations: fitting and non-fitting
    cfg_size_code = 3'd4; cfg_two_banks = 1'b0; alloc_req = 1'b1; step("R2 128x1 fits");
    cfg_size_code = 3'd4; cfg_two_banks = 1'b1; alloc_req = 1'b1; step("R2 128x2 too big");
    cfg_size_code = 3'd3; cfg_two_banks = 1'b1; alloc_req = 1'b1; step("R2 64x2 fits");
    cfg_size_code = 3'd7; cfg_two_banks = 1'b0; alloc_req = 1'b1; step("R2 1024 too big");
    cfg_size_code = 3'd0; cfg_two_banks = 1'b1; alloc_req = 1'b1; step("R2 8x2 fits");
    // R3 config changes without allocation
    cfg_size_code = 3'd6; cfg_two_banks = 1'b1; step("R3 hold");
    step("R3 hold again");

    // R4 flags set only when isochronous
    cfg_iso = 1'b0; ovf_evt = 1'b1; unf_evt = 1'b1; step("R4 non-iso ignored");
    cfg_iso = 1'b1; ovf_evt = 1'b1; step("R4 ovf set");
    unf_evt = 1'b1; step("R4 unf set");
    // R8 interrupt with enable
    flow_err_ie = 1'b1; step("R8 irq on");
    // R5 write ones keeps, write zero clears one bit only
    reg_wr = 1'b1; reg_wdata = 8'hFF; step("R5 write ones");
    reg_wr = 1'b1; reg_wdata = 8'b1101_1111; step("R5 clear unf only");
    reg_wr = 1'b1; reg_wdata = 8'h00; step("R5 clear ovf");
    step("R8 irq off");
    // R6 event beats acknowledge
    reg_wr = 1'b1; reg_wdata = 8'h00; ovf_evt = 1'b1; unf_evt = 1'b1; step("R6 race");
    // R7 flush beats event
    cfg_reset = 1'b1; ovf_evt = 1'b1; step("R7 cfg_reset");
    unf_evt = 1'b1; step("R7 set again");
    ep_enable = 1'b0; unf_evt = 1'b1; ovf_evt = 1'b1; step("R7 disabled");
    ep_enable = 1'b1; step("R7 re-enabled");

    // R9 toggle view per direction, busy banks
    rx_toggle = 2'b01; tx_toggle = 2'b00; busy_banks = 2'b10; cfg_dir_in = 1'b0;
    step("R9 OUT shows rx DATA1");
    cfg_dir_in = 1'b1; step("R9 IN shows tx DATA0");
    tx_toggle = 2'b01; rx_toggle = 2'b00; busy_banks = 2'b01; step("R9 IN DATA1");
    cfg_dir_in = 1'b0; step("R9 OUT DATA0");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule